// File: doc/BRIEF.md
# Prescaled Input Debounce Filter

This block cleans up one asynchronous input pin before later interrupt logic sees it. It runs on a slow clock of about 32.768 kHz. The raw pin first passes through a synchroniser. A time base, a prescaler that counts slow-clock cycles into units of a selectable size, then decides when a new level is allowed through. Configuration is held on plain inputs that a register block drives. It sets the filter policy, the unit size and a 4-bit count of units.

Four policies are available. The bypass policy passes the synchronised pin straight through. The symmetric policy lets a change of either polarity through only after it has stayed stable for the whole programmed time. The two asymmetric policies let one edge direction through at once and filter only the other direction. No data stream crosses the block, so it has no valid/ready handshake and no back-pressure. Every pin is a plain level.

Top module: `pin_deglitch`

## Requirements
- R1: While reset is held and directly after it, `pin_filt` is 0, the synchroniser is 0 and the unit timer is cleared.
- R2: With `db_mode`=0 (bypass), a pin change driven before clock edge 1 shows on `pin_filt` after edge 2. `db_tick_sel` and `db_count` have no effect in this mode.
- R3: `db_tick_sel` picks the unit length: 0 gives UNIT_LEN0, 1 gives UNIT_LEN1, 2 gives UNIT_LEN2 and 3 gives UNIT_LEN3 slow-clock cycles. The defaults are 2, 8, 512 and 2048. Bit 1 selects the large range and bit 0 selects the finer step within it.
- R4: With `db_mode`=1 (remove glitch), a change of either polarity must be seen on the synchronised input for M = N x unit consecutive cycles, where N is `db_count`. It then shows on `pin_filt` after edge M+2 from the pin change. A pulse shorter than M cycles never reaches the output.
- R5: A `db_count` of 0 in any filtering mode behaves as N = 1.
- R6: With `db_mode`=2 (keep low glitches), a falling change shows on `pin_filt` after edge 3, whatever its width. A rising change is filtered as in R4.
- R7: With `db_mode`=3 (keep high glitches), a rising change shows after edge 3. A falling change is filtered as in R4.
- R8: Whenever the synchronised input returns to the current output level, the progress of the unit timer is discarded. Two pulses of M-1 cycles separated by one cycle therefore never pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow filter clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| pin_raw | input | 1 | Asynchronous pin level |
| db_mode | input | 2 | Policy: 0 bypass, 1 remove, 2 keep low glitches, 3 keep high glitches |
| db_tick_sel | input | 2 | Unit length select |
| db_count | input | CNT_W | Number of units, 0 treated as 1 |
| pin_filt | output | 1 | Filtered pin level |

## Verification
The bench sweeps every filtering mode and every unit select over several counts, including 0 and the maximum. For each combination it applies pulses of exactly M and M-1 cycles in both polarities. Width M against M-1 pins down the threshold and the exact latency. Driving both polarities separates the symmetric policy from the two one-sided ones, because only one-sided policies pass an edge within three cycles. Two near-threshold pulses split by a single idle cycle show whether progress is discarded. Single-cycle pulses in bypass, with the timing fields at their extremes, show that those fields are ignored there.

// File: rtl/pin_deglitch_pkg.sv
package pin_deglitch_pkg;

  typedef enum logic [1:0] {
    DB_BYPASS    = 2'd0,
    DB_REMOVE    = 2'd1,
    DB_KEEP_LOW  = 2'd2,
    DB_KEEP_HIGH = 2'd3
  } db_mode_e;

  // True when a move towards level nxt skips the timer under mode m.
  function automatic logic passes_at_once(db_mode_e m, logic nxt);
    return ((m == DB_KEEP_LOW) && !nxt) || ((m == DB_KEEP_HIGH) && nxt);
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pd_unit_timer.sv
module pd_unit_timer
  import pin_deglitch_pkg::*;
#(
  parameter int unsigned UNIT_LEN0 = 2,
  parameter int unsigned UNIT_LEN1 = 8,
  parameter int unsigned UNIT_LEN2 = 512,
  parameter int unsigned UNIT_LEN3 = 2048,
  parameter int          CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [1:0]       tick_sel,
  input  logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam int unsigned UNIT_MAX = max4(UNIT_LEN0, UNIT_LEN1, UNIT_LEN2, UNIT_LEN3);
  localparam int          PRE_W    = $clog2(UNIT_MAX + 1);
  localparam int unsigned LENS [4] = '{UNIT_LEN0, UNIT_LEN1, UNIT_LEN2, UNIT_LEN3};

  logic [PRE_W-1:0] last_tab [4];
  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] unit_cnt;
  logic [PRE_W-1:0] last_pre;
  logic [CNT_W-1:0] goal;
  logic             unit_end;

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_len
      assign last_tab[g] = PRE_W'(LENS[g] - 1);
    end
  endgenerate

  always_comb begin
    last_pre = last_tab[tick_sel];
    goal     = (count == '0) ? '0 : count - 1'b1;
    unit_end = (pre_cnt >= last_pre);
    expire   = !clear && unit_end && (unit_cnt >= goal);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pre_cnt  <= '0;
      unit_cnt <= '0;
    end else if (unit_end) begin
      pre_cnt  <= '0;
      unit_cnt <= expire ? '0 : unit_cnt + 1'b1;
    end else begin
      pre_cnt  <= pre_cnt + 1'b1;
    end
  end

  // R8: a clear request wipes all progress by the next cycle
  p_clear_wipes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pre_cnt == '0) && (unit_cnt == '0));

  // R3: the prescaler never runs past the longest unit
  p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt < PRE_W'(UNIT_MAX));

endmodule

// File: rtl/pd_decide.sv
module pd_decide
  import pin_deglitch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic [1:0] mode_raw,
  input  logic       expire,
  output logic       clear,
  output logic       filt
);
  db_mode_e mode;
  logic     out_q;
  logic     differs;
  logic     quick;

  always_comb begin
    mode    = db_mode_e'(mode_raw);
    differs = (sync_in != out_q);
    quick   = passes_at_once(mode, sync_in);
    clear   = (mode == DB_BYPASS) || !differs || quick;
    filt    = (mode == DB_BYPASS) ? sync_in : out_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      out_q <= 1'b0;
    else if ((mode == DB_BYPASS) || (differs && quick) || expire)
      out_q <= sync_in;
  end

  // R4: any update of the held level adopts the synchronised input
  p_settle_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> (out_q == $past(sync_in)));

  // R4: in the symmetric policy nothing moves without timer expiry
  p_remove_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == DB_REMOVE) && !expire) |=> $stable(out_q));

  // R6: falling edges pass at once when low glitches are kept
  p_fast_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == DB_KEEP_LOW) && out_q && !sync_in) |=> !out_q);

  // R7: rising edges pass at once when high glitches are kept
  p_fast_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == DB_KEEP_HIGH) && !out_q && sync_in) |=> out_q);

endmodule

// File: rtl/pin_deglitch.sv
module pin_deglitch
  import pin_deglitch_pkg::*;
#(
  parameter int unsigned UNIT_LEN0   = 2,
  parameter int unsigned UNIT_LEN1   = 8,
  parameter int unsigned UNIT_LEN2   = 512,
  parameter int unsigned UNIT_LEN3   = 2048,
  parameter int          CNT_W       = 4,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_raw,
  input  logic [1:0]       db_mode,
  input  logic [1:0]       db_tick_sel,
  input  logic [CNT_W-1:0] db_count,
  output logic             pin_filt
);
  logic sync_in;
  logic clear;
  logic expire;

  pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_raw),
    .q     (sync_in)
  );

  pd_unit_timer #(
    .UNIT_LEN0 (UNIT_LEN0),
    .UNIT_LEN1 (UNIT_LEN1),
    .UNIT_LEN2 (UNIT_LEN2),
    .UNIT_LEN3 (UNIT_LEN3),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .tick_sel (db_tick_sel),
    .count    (db_count),
    .expire   (expire)
  );

  pd_decide u_decide (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  (sync_in),
    .mode_raw (db_mode),
    .expire   (expire),
    .clear    (clear),
    .filt     (pin_filt)
  );

  // R1: the filtered level is low in the first cycle after reset
  p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pin_filt);

endmodule

// File: tb/pin_deglitch_tb.sv
`timescale 1ns/1ps
module pin_deglitch_tb;
  localparam int unsigned L0 = 2, L1 = 3, L2 = 4, L3 = 5;
  localparam int unsigned LEN [4] = '{L0, L1, L2, L3};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_raw = 1'b0;
  logic [1:0] db_mode = 2'd0;
  logic [1:0] db_tick_sel = 2'd0;
  logic [3:0] db_count = 4'd0;
  logic       pin_filt;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pin_deglitch #(.UNIT_LEN0(L0), .UNIT_LEN1(L1), .UNIT_LEN2(L2), .UNIT_LEN3(L3),
                 .CNT_W(4), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .db_mode(db_mode),
    .db_tick_sel(db_tick_sel), .db_count(db_count), .pin_filt(pin_filt));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive ~base for w edges, then base; report index of first output change.
  task automatic pulse(input int w, input logic base, input int horizon, output int first);
    first = -1;
    @(negedge clk) pin_raw = ~base;
    for (int i = 1; i <= horizon; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (first < 0 && pin_filt != base) first = i;
      if (i == w) pin_raw = base;
    end
  endtask

  task automatic settle(input logic lvl, input int cyc, input string tag);
    @(negedge clk) pin_raw = lvl;
    repeat (cyc) @(negedge clk);
    check(pin_filt == lvl, tag, pin_filt, lvl);
  endtask

  function automatic int expect_first(int mode, logic to_lvl, int w, int m);
    if ((mode == 2 && !to_lvl) || (mode == 3 && to_lvl)) return 3;
    return (w >= m) ? m + 2 : -1;
  endfunction

  initial begin
    int first;
    int cnts [5] = '{0, 1, 2, 7, 15};
    repeat (4) @(negedge clk);
    check(pin_filt == 1'b0, "R1 output low in reset", pin_filt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pin_filt == 1'b0, "R1 output low after reset", pin_filt, 0);

    // R2: bypass latency with timing fields at extremes
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 2; c++) begin
        db_mode = 2'd0; db_tick_sel = 2'(s); db_count = c ? 4'd15 : 4'd0;
        pulse(1, 1'b0, 8, first);
        check(first == 2, "R2 bypass rise latency", first, 2);
        check(pin_filt == 1'b0, "R2 bypass single-cycle return", pin_filt, 0);
      end
    end

    // R3..R7: sweep modes, unit selects and counts
    for (int md = 1; md < 4; md++) begin
      for (int s = 0; s < 4; s++) begin
        for (int k = 0; k < 5; k++) begin
          int n, m;
          n = (cnts[k] == 0) ? 1 : cnts[k];   // R5
          m = n * int'(LEN[s]);               // R3
          db_mode = 2'(md); db_tick_sel = 2'(s); db_count = 4'(cnts[k]);
          settle(1'b0, m + 8, "R4 idle low");
          for (int d = 0; d < 2; d++) begin
            logic base;
            base = d[0];
            for (int w = m - 1; w <= m; w++) begin
              int e;
              e = expect_first(md, ~base, w, m);
              pulse(w, base, w + m + 8, first);
              if (md == 1)
                check(first == e, "R4 remove threshold/latency", first, e);
              else if (md == 2)
                check(first == e, "R6 keep-low edge", first, e);
              else
                check(first == e, "R7 keep-high edge", first, e);
              if (cnts[k] == 0)
                check(first == e, "R5 zero count as one unit", first, e);
              settle(base, m + 8, "R4 return to base");
            end
            if (d == 0) settle(1'b1, m + 8, "R4 move to high");
          end
          // R8: two near-threshold pulses with a one-cycle gap
          if (md == 1 && m > 2) begin
            settle(1'b0, m + 8, "R8 idle low");
            first = -1;
            @(negedge clk) pin_raw = 1'b1;
            for (int i = 1; i <= 3 * m + 8; i++) begin
              @(posedge clk);
              @(negedge clk);
              if (first < 0 && pin_filt) first = i;
              if (i == m - 1) pin_raw = 1'b0;
              if (i == m)     pin_raw = 1'b1;
              if (i == 2 * m - 1) pin_raw = 1'b0;
            end
            check(first == -1, "R8 progress discarded", first, -1);
          end
        end
      end
    end
    settle(1'b0, 90, "R4 final low");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule